// File: doc/BRIEF.md
# Character Display Parallel Host Port

This block is the slave side of the parallel bus that a microcontroller uses to talk to a character display controller. The host drives a register-select line, a read/write line and an enable strobe, and moves data over a bidirectional data bus. The bus can be eight lines wide or four lines wide. The block brings the asynchronous enable into the system clock domain through a synchroniser and acts on its falling edge. It routes each completed write either to the instruction executor as a command byte or to the display RAM port as a data byte.

For reads, the block drives the bus only while enable is high on a read access. When register select is 0, the read returns a status byte: the busy flag in bit 7 and the address counter in bits 6 to 0. When register select is 1, the read returns the display RAM byte, and after the access ends the block sends a single-cycle read strobe so the RAM side can move on. In the four-line mode every byte, written or read, travels as two halves on lines 7 to 4. The upper half goes first. A half-select flag records which half comes next.

Top module: `lcd_host_if`

## Requirements
- R1: After reset the data bus output enable is 0, no strobe (cmd_valid, ram_wr, ram_rd) is asserted, and the next four-line transfer is treated as the upper half.
- R2: In eight-line mode (narrow_mode=0), a write with bus_rs=0 and bus_rw=0 gives exactly one cmd_valid pulse after enable falls, with cmd_byte equal to bus_d_i as held at the falling edge.
- R3: In eight-line mode, a write with bus_rs=1 and bus_rw=0 gives exactly one ram_wr pulse with ram_wdata equal to bus_d_i, and no cmd_valid.
- R4: A read with bus_rs=0 and bus_rw=1 drives bus_d_o = {busy, addr_cnt[6:0]} while enable is high, and produces no strobe.
- R5: A read with bus_rs=1 and bus_rw=1 drives bus_d_o = ram_rdata while enable is high, and gives exactly one ram_rd pulse after enable falls.
- R6: bus_d_oe is 1 only while the synchronised enable is high on a read access. It is 0 after enable falls and throughout write accesses.
- R7: In four-line mode (narrow_mode=1), the first write access supplies bits 7:4 of the byte and the second supplies bits 3:0, both taken from bus_d_i[7:4]. bus_d_i[3:0] is ignored. No strobe follows the first access, and one strobe follows the second.
- R8: In four-line mode a read drives the upper half of the read byte on bus_d_o[7:4] in the first access and the lower half in the second, with bus_d_o[3:0] = 0.
- R9: Any change of narrow_mode returns the half-select flag to the upper half, so a half-finished byte is discarded.
- R10: Each strobe lasts one clock cycle, and at most one of cmd_valid, ram_wr and ram_rd is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_mode | input | 1 | 1 selects the four-line bus, 0 the eight-line bus |
| bus_rs | input | 1 | Register select: 0 command/status, 1 display data |
| bus_rw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Asynchronous transfer strobe from the host |
| bus_d_i | input | 8 | Data bus input side |
| bus_d_o | output | 8 | Data bus output side |
| bus_d_oe | output | 1 | Data bus output enable (bus is high-impedance when 0) |
| busy | input | 1 | Busy flag from the instruction executor |
| addr_cnt | input | 7 | Address counter value |
| ram_rdata | input | 8 | Byte read from display RAM |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| ram_wr | output | 1 | One-cycle display RAM write strobe |
| ram_wdata | output | 8 | Display RAM write byte |
| ram_rd | output | 1 | One-cycle strobe after a completed data read |

## Verification
The hardest state to reach from the ports is a four-line byte left half-finished when the mode changes. To reach it, the stimulus sends one upper-half write, switches to eight-line mode for a few cycles, switches back, and then sends two new halves. The expected byte is built only from the two new halves. A second hard case is a four-line read. Here the output half depends on a flag that changes only on enable falling edges, so the bench samples the bus while enable is high in each of two accesses and compares it with the halves of the status byte it composed itself.

// File: rtl/lcd_if_pkg.sv
package lcd_if_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = BYTE_W / 2;
  localparam int ADDR_W = BYTE_W - 1;

  // status byte: busy flag at the top, address counter below it
  function automatic logic [BYTE_W-1:0] status_word(input logic bsy,
                                                    input logic [ADDR_W-1:0] ac);
    return {bsy, ac};
  endfunction

  function automatic logic [HALF_W-1:0] pick_half(input logic [BYTE_W-1:0] b,
                                                  input logic lower);
    return lower ? b[HALF_W-1:0] : b[BYTE_W-1:HALF_W];
  endfunction

  function automatic logic [BYTE_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  // a half placed on the upper lines, lower lines held at zero
  function automatic logic [BYTE_W-1:0] on_upper_lines(input logic [HALF_W-1:0] h);
    return {h, {HALF_W{1'b0}}};
  endfunction
endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic en_level,
  output logic en_fall
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= en_async;
  end

  genvar gi;
  generate
    for (gi = 1; gi < CHAIN_W; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[gi] <= 1'b0;
        else        chain[gi] <= chain[gi-1];
      end
    end
  endgenerate

  assign en_level = chain[STAGES-1];
  assign en_fall  = chain[STAGES] & ~chain[STAGES-1];

  // R10: a falling edge is never reported on two consecutive cycles
  a_r10_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !en_fall);
endmodule

// File: rtl/lcd_nibble_asm.sv
module lcd_nibble_asm
  import lcd_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow,
  input  logic              fall,
  input  logic              rs_in,
  input  logic              rw_in,
  input  logic [BYTE_W-1:0] d_in,
  output logic              lower_next,
  output logic              byte_done,
  output logic              byte_rs,
  output logic              byte_rw,
  output logic [BYTE_W-1:0] byte_val
);
  logic              narrow_q;
  logic              mode_flip;
  logic [HALF_W-1:0] hi_hold;

  assign mode_flip = narrow ^ narrow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      narrow_q   <= 1'b0;
      lower_next <= 1'b0;
      hi_hold    <= '0;
      byte_done  <= 1'b0;
      byte_rs    <= 1'b0;
      byte_rw    <= 1'b0;
      byte_val   <= '0;
    end else begin
      narrow_q  <= narrow;
      byte_done <= 1'b0;
      if (mode_flip) begin
        lower_next <= 1'b0;
      end else if (fall) begin
        byte_rs <= rs_in;
        byte_rw <= rw_in;
        if (!narrow) begin
          byte_val  <= d_in;
          byte_done <= 1'b1;
        end else if (!lower_next) begin
          hi_hold    <= pick_half(d_in, 1'b0);
          lower_next <= 1'b1;
        end else begin
          byte_val   <= join_halves(hi_hold, pick_half(d_in, 1'b0));
          byte_done  <= 1'b1;
          lower_next <= 1'b0;
        end
      end
    end
  end

  // R9: in steady eight-line mode the half flag never leaves the upper half
  a_r9_wide_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow && !narrow_q) |=> !lower_next);
  // R7: a completed byte is always the consequence of a falling edge
  a_r7_done_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(fall));
endmodule

// File: rtl/lcd_read_path.sv
module lcd_read_path
  import lcd_if_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_level,
  input  logic              fall,
  input  logic              rs_in,
  input  logic              rw_in,
  input  logic              narrow,
  input  logic              lower_next,
  input  logic              bsy,
  input  logic [ADDR_W-1:0] ac,
  input  logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] d_out,
  output logic              oe
);
  logic [BYTE_W-1:0] word;
  logic [BYTE_W-1:0] shaped;

  always_comb begin
    word   = rs_in ? rdata : status_word(bsy, ac);
    shaped = narrow ? on_upper_lines(pick_half(word, lower_next)) : word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe    <= 1'b0;
      d_out <= '0;
    end else begin
      oe    <= en_level & rw_in;
      d_out <= (en_level & rw_in) ? shaped : '0;
    end
  end

  // R6: the bus is released in the cycle right after enable falls
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !oe);
  // R8: in four-line mode the lower lines are never driven high
  a_r8_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(narrow)) |-> (d_out[HALF_W-1:0] == '0));
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
  import lcd_if_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              narrow_mode,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic              bus_en,
  input  logic [BYTE_W-1:0] bus_d_i,
  output logic [BYTE_W-1:0] bus_d_o,
  output logic              bus_d_oe,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr_cnt,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              ram_wr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              ram_rd
);
  logic              en_level;
  logic              en_fall;
  logic              lower_next;
  logic              byte_done;
  logic              byte_rs;
  logic              byte_rw;
  logic [BYTE_W-1:0] byte_val;

  lcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_async (bus_en),
    .en_level (en_level),
    .en_fall  (en_fall)
  );

  lcd_nibble_asm u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .narrow     (narrow_mode),
    .fall       (en_fall),
    .rs_in      (bus_rs),
    .rw_in      (bus_rw),
    .d_in       (bus_d_i),
    .lower_next (lower_next),
    .byte_done  (byte_done),
    .byte_rs    (byte_rs),
    .byte_rw    (byte_rw),
    .byte_val   (byte_val)
  );

  lcd_read_path u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_level   (en_level),
    .fall       (en_fall),
    .rs_in      (bus_rs),
    .rw_in      (bus_rw),
    .narrow     (narrow_mode),
    .lower_next (lower_next),
    .bsy        (busy),
    .ac         (addr_cnt),
    .rdata      (ram_rdata),
    .d_out      (bus_d_o),
    .oe         (bus_d_oe)
  );

  assign cmd_valid = byte_done & ~byte_rw & ~byte_rs;
  assign ram_wr    = byte_done & ~byte_rw &  byte_rs;
  assign ram_rd    = byte_done &  byte_rw &  byte_rs;
  assign cmd_byte  = byte_val;
  assign ram_wdata = byte_val;

  // R10: strobes are exclusive and one cycle wide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, ram_wr, ram_rd}));
  a_r10_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |=> !ram_wr);
  // R6: the bus is never driven while a write strobe is issued
  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || ram_wr) |-> !bus_d_oe);
endmodule

// File: tb/lcd_host_if_tb.sv
module lcd_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       narrow_mode = 1'b0;
  logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
  logic [7:0] bus_d_i = 8'h00;
  logic [7:0] bus_d_o;
  logic       bus_d_oe;
  logic       busy = 1'b1;
  logic [6:0] addr_cnt = 7'h35;
  logic [7:0] ram_rdata = 8'hC3;
  logic       cmd_valid, ram_wr, ram_rd;
  logic [7:0] cmd_byte, ram_wdata;

  int n_chk = 0, n_bad = 0;
  int n_cmd = 0, n_wr = 0, n_rd = 0;
  logic [7:0] last_cmd = 8'h00, last_wr = 8'h00;

  always #5ns clk = ~clk;

  lcd_host_if u_dut (
    .clk(clk), .rst_n(rst_n), .narrow_mode(narrow_mode),
    .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en),
    .bus_d_i(bus_d_i), .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe),
    .busy(busy), .addr_cnt(addr_cnt), .ram_rdata(ram_rdata),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .ram_wr(ram_wr), .ram_wdata(ram_wdata), .ram_rd(ram_rd)
  );

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin n_cmd++; last_cmd = cmd_byte; end
    if (ram_wr)    begin n_wr++;  last_wr  = ram_wdata; end
    if (ram_rd)    n_rd++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] rd, output logic oe_hi, output logic oe_after);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_d_i = d;
    repeat (2) @(negedge clk);
    bus_en = 1'b1;
    repeat (6) @(negedge clk);
    rd = bus_d_o; oe_hi = bus_d_oe;
    bus_en = 1'b0;
    repeat (6) @(negedge clk);
    oe_after = bus_d_oe;
  endtask

  // {rs, data} for eight-line writes
  localparam logic [8:0] VEC [6] = '{9'h0_38, 9'h1_41, 9'h0_01, 9'h1_FF, 9'h1_00, 9'h0_80};

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic oh, oa;
    int c0, w0, r0;
    repeat (4) @(negedge clk);
    chk("R1 oe at reset", bus_d_oe, 0);
    chk("R1 strobes at reset", {cmd_valid, ram_wr, ram_rd}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      c0 = n_cmd; w0 = n_wr;
      xfer(VEC[i][8], 1'b0, VEC[i][7:0], rd, oh, oa);
      if (VEC[i][8]) begin
        chk("R3 ram_wr count", n_wr - w0, 1);
        chk("R3 ram_wdata", last_wr, VEC[i][7:0]);
        chk("R3 no cmd", n_cmd - c0, 0);
      end else begin
        chk("R2 cmd count", n_cmd - c0, 1);
        chk("R2 cmd_byte", last_cmd, VEC[i][7:0]);
        chk("R2 no ram_wr", n_wr - w0, 0);
      end
      chk("R6 oe during write", oh, 0);
    end

    c0 = n_cmd; w0 = n_wr; r0 = n_rd;
    xfer(1'b0, 1'b1, 8'h00, rd, oh, oa);
    chk("R4 status byte", rd, 8'hB5);
    chk("R6 oe during read", oh, 1);
    chk("R6 oe after read", oa, 0);
    chk("R4 no strobe", (n_cmd - c0) + (n_wr - w0) + (n_rd - r0), 0);

    busy = 1'b0; addr_cnt = 7'h7F;
    xfer(1'b0, 1'b1, 8'h00, rd, oh, oa);
    chk("R4 status not busy", rd, 8'h7F);

    r0 = n_rd;
    xfer(1'b1, 1'b1, 8'h00, rd, oh, oa);
    chk("R5 data read", rd, 8'hC3);
    chk("R5 ram_rd count", n_rd - r0, 1);

    // four-line mode
    @(negedge clk); narrow_mode = 1'b1; repeat (3) @(negedge clk);
    c0 = n_cmd;
    xfer(1'b0, 1'b0, 8'h7F, rd, oh, oa);
    chk("R7 no strobe after first half", n_cmd - c0, 0);
    xfer(1'b0, 1'b0, 8'h2E, rd, oh, oa);
    chk("R7 one strobe after second half", n_cmd - c0, 1);
    chk("R7 joined byte", last_cmd, 8'h72);

    w0 = n_wr;
    xfer(1'b1, 1'b0, 8'hA5, rd, oh, oa);
    xfer(1'b1, 1'b0, 8'h90, rd, oh, oa);
    chk("R7 ram byte", last_wr, 8'hA9);
    chk("R7 ram count", n_wr - w0, 1);

    busy = 1'b1; addr_cnt = 7'h35;
    xfer(1'b0, 1'b1, 8'h00, rd, oh, oa);
    chk("R8 upper half", rd, 8'hB0);
    xfer(1'b0, 1'b1, 8'h00, rd, oh, oa);
    chk("R8 lower half", rd, 8'h50);

    r0 = n_rd;
    xfer(1'b1, 1'b1, 8'h00, rd, oh, oa);
    chk("R8 data upper", rd, 8'hC0);
    chk("R8 no ram_rd after half", n_rd - r0, 0);
    xfer(1'b1, 1'b1, 8'h00, rd, oh, oa);
    chk("R8 data lower", rd, 8'h30);
    chk("R5 ram_rd after byte", n_rd - r0, 1);

    // R9: half-finished byte discarded on mode change
    c0 = n_cmd;
    xfer(1'b0, 1'b0, 8'hE0, rd, oh, oa);
    @(negedge clk); narrow_mode = 1'b0; repeat (3) @(negedge clk);
    narrow_mode = 1'b1; repeat (3) @(negedge clk);
    xfer(1'b0, 1'b0, 8'h30, rd, oh, oa);
    chk("R9 no strobe after restart half", n_cmd - c0, 0);
    xfer(1'b0, 1'b0, 8'hC0, rd, oh, oa);
    chk("R9 fresh byte", last_cmd, 8'h3C);
    chk("R9 strobe count", n_cmd - c0, 1);

    // R1: reset in the middle of a byte returns to the upper half
    xfer(1'b0, 1'b0, 8'h10, rd, oh, oa);
    @(negedge clk); rst_n = 1'b0; repeat (3) @(negedge clk);
    chk("R1 oe in reset", bus_d_oe, 0);
    rst_n = 1'b1; repeat (2) @(negedge clk);
    c0 = n_cmd;
    xfer(1'b0, 1'b0, 8'h40, rd, oh, oa);
    xfer(1'b0, 1'b0, 8'h20, rd, oh, oa);
    chk("R1 upper half after reset", last_cmd, 8'h42);
    chk("R10 single pulse per byte", n_cmd - c0, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule